// File: doc/BRIEF.md
# Paired-Lane Single-Precision Compare Unit

This block compares two 64-bit operands. Each operand packs two IEEE-754 single-precision numbers, one per 32-bit lane. Both lanes are evaluated at the same time under one 4-bit predicate code, which gives one condition bit per lane. On a strobe, the two bits are stored in adjacent entries of an 8-entry condition register. They are also held on a registered lane-result output, and an invalid-operation flag is raised for one cycle when the NaN rules call for it.

The low three predicate bits form a uniform datapath. One bit makes an unordered lane report true. One bit lets equality make the lane true. One bit lets strict less-than make the lane true. The top bit selects the signaling form. The signaling form produces the same condition bits, but any NaN raises the invalid flag, not just a signaling NaN.

Ordering follows IEEE rules. The two zeros are equal. Negative values order by reversed magnitude. Any NaN makes a lane unordered. A base index that would place the upper lane past the last register entry is refused: a one-cycle error pulse is raised and no state changes.

Top module: `pair_fcmp_unit`

## Requirements
- R1: After synchronous reset, `ccr`, `lane_cond`, `inv_op` and `cc_err` are all zero.
- R2: Lane 0 is operand bits 31:0 and lane 1 is bits 63:32. On an accepted strobe, lane 0's result goes to `lane_cond[0]` and `ccr[cc_sel]`, and lane 1's result goes to `lane_cond[1]` and `ccr[cc_sel+1]`, one cycle after the strobe edge.
- R3: A lane is unordered when either of its operands has an all-ones exponent and a non-zero fraction. An unordered lane's result equals `pred[0]`.
- R4: For an ordered lane, the result is (`pred[1]` AND equal) OR (`pred[2]` AND less-than). Codes 0..7 are therefore: never, unordered, equal, unordered-or-equal, less, unordered-or-less, less-or-equal, unordered-or-less-or-equal.
- R5: +0 and -0 compare equal, and neither is less than the other.
- R6: Less-than follows real-number order. For two negative values, the larger magnitude is the smaller value, and any negative non-zero value is below any positive value.
- R7: `pred[3]` has no effect on the condition bits. Codes 8..15 give the same results as codes 0..7.
- R8: With `pred[3]`=1, `inv_op` pulses for one cycle when any operand in either lane is a NaN of either kind.
- R9: With `pred[3]`=0, `inv_op` pulses only when some operand is a signaling NaN, meaning a NaN whose fraction bit 22 is clear. Quiet NaNs (bit 22 set) do not raise it.
- R10: A strobe with `cc_sel`=7 pulses `cc_err` for one cycle. It leaves `ccr` and `lane_cond` unchanged and keeps `inv_op` low.
- R11: With `cmp_en` low, `ccr` and `lane_cond` hold, and `inv_op` and `cc_err` are low on the next cycle.
- R12: An accepted write changes only the two addressed `ccr` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | 1 | Compare strobe |
| pred | input | 4 | Predicate: [3] signaling, [2] less, [1] equal, [0] unordered |
| cc_sel | input | 3 | Register index for lane 0 (lane 1 uses the next index) |
| src_s | input | 64 | First operand, two packed singles |
| src_t | input | 64 | Second operand, two packed singles |
| lane_cond | output | 2 | Registered per-lane results of the last accepted compare |
| inv_op | output | 1 | One-cycle invalid-operation pulse |
| cc_err | output | 1 | One-cycle illegal register-index pulse |
| ccr | output | 8 | Condition register contents |

## Verification
The hardest cases to reach are those where the two lanes disagree on NaN class while the signaling bit flips. The invalid flag is the OR over both lanes, so a signaling NaN hidden in the upper lane must not be masked by a clean lower lane. The zero and negative orderings, which only show under the less-than codes, are equally hard to reach. The stimulus sweeps a value set that holds quiet and signaling NaNs, both infinities, both zeros, the smallest subnormal and mixed-sign normals. It places those values in the two lanes with different rotations and runs every pair under all sixteen codes, with the register index cycling over every legal base. Each result is compared with an integer ordering model.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

  // Predicate bits: [3] sig, [2] lt_en, [1] eq_en, [0] un_en
  typedef struct packed {
    logic sig;
    logic lt_en;
    logic eq_en;
    logic un_en;
  } pred_t;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
    logic neg;
  } fcls_t;

endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import pcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0]   word,
  output fcls_t                   cls,
  output logic [EXP_W+FRAC_W-1:0] mag
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              frac_nz;

  assign exp_f    = word[W-2:FRAC_W];
  assign frac_f   = word[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    cls.is_nan  = exp_ones & frac_nz;
    cls.is_snan = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
    cls.is_zero = ~|word[W-2:0];
    cls.neg     = word[W-1];
  end

  assign mag = word[W-2:0];

endmodule

// File: rtl/lane_cmp.sv
module lane_cmp
  import pcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  pred_t                 pred,
  output logic                  cond,
  output logic                  unord,
  output logic                  inv
);
  localparam int MW = EXP_W + FRAC_W;

  fcls_t         ca, cb;
  logic [MW-1:0] ma, mb;
  logic          both_zero;
  logic          eq;
  logic          lt;

  fp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (.word(a), .cls(ca), .mag(ma));
  fp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (.word(b), .cls(cb), .mag(mb));

  assign both_zero = ca.is_zero & cb.is_zero;
  assign eq        = both_zero | (a == b);

  always_comb begin
    if (both_zero) begin
      lt = 1'b0;
    end else begin
      unique case ({ca.neg, cb.neg})
        2'b10:   lt = 1'b1;
        2'b01:   lt = 1'b0;
        2'b00:   lt = (ma < mb);
        default: lt = (ma > mb);
      endcase
    end
  end

  assign unord = ca.is_nan | cb.is_nan;
  assign cond  = unord ? pred.un_en : ((pred.eq_en & eq) | (pred.lt_en & lt));
  assign inv   = pred.sig ? unord : (ca.is_snan | cb.is_snan);

  always_comb begin
    if (unord) begin
      a_r3_unord_follows_u : assert (cond == pred.un_en);
    end
    if (!pred.sig && !ca.is_snan && !cb.is_snan) begin
      a_r9_quiet_nan_silent : assert (!inv);
    end
    if (both_zero && !unord) begin
      a_r5_zero_not_less : assert (!lt && eq);
    end
  end

endmodule

// File: rtl/ccr_bank.sv
module ccr_bank #(
  parameter int CC_N  = 8,
  parameter int LANES = 2,
  parameter int IDX_W = $clog2(CC_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] base,
  input  logic [LANES-1:0] bits,
  output logic [CC_N-1:0]  ccr
);
  logic [CC_N-1:0] nxt;

  always_comb begin
    nxt = ccr;
    for (int g = 0; g < CC_N; g++) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_en && (int'(base) + i == g)) nxt[g] = bits[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ccr <= '0;
    else     ccr <= nxt;
  end

endmodule

// File: rtl/pair_fcmp_unit.sv
module pair_fcmp_unit
  import pcmp_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int CC_N   = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cmp_en,
  input  logic [3:0]                       pred,
  input  logic [$clog2(CC_N)-1:0]          cc_sel,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] src_s,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] src_t,
  output logic [LANES-1:0]                 lane_cond,
  output logic                             inv_op,
  output logic                             cc_err,
  output logic [CC_N-1:0]                  ccr
);
  localparam int LW       = 1 + EXP_W + FRAC_W;
  localparam int IDX_W    = $clog2(CC_N);
  localparam int MAX_BASE = CC_N - LANES;

  pred_t            p;
  logic [LANES-1:0] cond_w;
  logic [LANES-1:0] unord_w;
  logic [LANES-1:0] inv_w;
  logic             cc_ok;
  logic             wr;

  assign p = pred_t'(pred);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_cmp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lane (
      .a    (src_s[g*LW +: LW]),
      .b    (src_t[g*LW +: LW]),
      .pred (p),
      .cond (cond_w[g]),
      .unord(unord_w[g]),
      .inv  (inv_w[g])
    );
  end

  assign cc_ok = (int'(cc_sel) <= MAX_BASE);
  assign wr    = cmp_en & cc_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_cond <= '0;
      inv_op    <= 1'b0;
      cc_err    <= 1'b0;
    end else begin
      inv_op <= wr & (|inv_w);
      cc_err <= cmp_en & ~cc_ok;
      if (wr) lane_cond <= cond_w;
    end
  end

  ccr_bank #(.CC_N(CC_N), .LANES(LANES), .IDX_W(IDX_W)) u_ccr (
    .clk  (clk),
    .rst  (rst),
    .wr_en(wr),
    .base (cc_sel),
    .bits (cond_w),
    .ccr  (ccr)
  );

  a_r10_bad_index_no_write : assert property (@(posedge clk) disable iff (rst)
    (cmp_en && !cc_ok) |=> (cc_err && !inv_op && $stable(ccr) && $stable(lane_cond)));

  a_r11_idle_quiet : assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> (!cc_err && !inv_op && $stable(ccr) && $stable(lane_cond)));

  a_r2_low_lane_stored : assert property (@(posedge clk) disable iff (rst)
    wr |=> (ccr[$past(cc_sel)] == lane_cond[0]));

  a_r2_high_lane_stored : assert property (@(posedge clk) disable iff (rst)
    wr |=> (ccr[$past(cc_sel) + 1'b1] == lane_cond[1]));

  a_r8_sig_unord_raises : assert property (@(posedge clk) disable iff (rst)
    (wr && p.sig && (|unord_w)) |=> inv_op);

endmodule

// File: tb/pair_fcmp_unit_tb_top.sv
`timescale 1ns/1ps
module pair_fcmp_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmp_en;
  logic [3:0]  pred;
  logic [2:0]  cc_sel;
  logic [63:0] src_s, src_t;
  logic [1:0]  lane_cond;
  logic        inv_op, cc_err;
  logic [7:0]  ccr;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  logic [7:0] exp_ccr;

  always #10 clk = ~clk;

  pair_fcmp_unit dut_i (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .pred(pred), .cc_sel(cc_sel),
    .src_s(src_s), .src_t(src_t), .lane_cond(lane_cond), .inv_op(inv_op),
    .cc_err(cc_err), .ccr(ccr)
  );

  localparam logic [31:0] QNAN = 32'h7FC00000, SNAN = 32'h7F800001, PINF = 32'h7F800000,
                          NINF = 32'hFF800000, PZ = 32'h00000000, NZ = 32'h80000000,
                          P1 = 32'h3F800000, N1 = 32'hBF800000, P2 = 32'h40000000,
                          N2 = 32'hC0000000, TINY = 32'h00000001, NSNAN = 32'hFFA00000;

  function automatic logic [31:0] val(input int k);
    case (k % 12)
      0: return QNAN;  1: return SNAN;  2: return PINF;  3: return NINF;
      4: return PZ;    5: return NZ;    6: return P1;    7: return N1;
      8: return P2;    9: return N2;    10: return TINY; default: return NSNAN;
    endcase
  endfunction

  // returns {inv, cond} for one lane, integer ordering model
  function automatic logic [1:0] ref_lane(input logic [31:0] a, b, input logic [3:0] p);
    logic nan_a, nan_b, sn_a, sn_b, un, c, iv;
    longint va, vb;
    nan_a = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nan_b = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    sn_a  = nan_a && !a[22];
    sn_b  = nan_b && !b[22];
    va = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
    vb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
    un = nan_a || nan_b;
    c  = un ? p[0] : ((p[1] && va == vb) || (p[2] && va < vb));
    iv = p[3] ? un : (sn_a || sn_b);
    return {iv, c};
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [63:0] s, t, input logic [3:0] p, input logic [2:0] c,
                         input string tag);
    logic [1:0] r0, r1;
    r0 = ref_lane(s[31:0], t[31:0], p);
    r1 = ref_lane(s[63:32], t[63:32], p);
    exp_ccr[c]              = r0[0];
    exp_ccr[int'(c) + 1]    = r1[0];
    @(negedge clk);
    src_s = s; src_t = t; pred = p; cc_sel = c; cmp_en = 1'b1;
    @(negedge clk);
    check(tag, "lane_cond", 64'(lane_cond), 64'({r1[0], r0[0]}));
    check(p[3] ? "R8" : "R9", "inv_op", 64'(inv_op), 64'(r0[1] | r1[1]));
    check("R12", "ccr", 64'(ccr), 64'(exp_ccr));
    check("R10", "cc_err", 64'(cc_err), 64'd0);
    cmp_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "ccr", 64'(ccr), 64'd0);
    check("R1", "lane_cond", 64'(lane_cond), 64'd0);
    check("R1", "inv_op", 64'(inv_op), 64'd0);
    check("R1", "cc_err", 64'(cc_err), 64'd0);
  endtask

  task automatic t_lanes;  // R2
    run_vec({P2, P1}, {P1, P2}, 4'd4, 3'd3, "R2");
    check("R2", "ccr[3]", 64'(ccr[3]), 64'd1);
    check("R2", "ccr[4]", 64'(ccr[4]), 64'd0);
    run_vec({P1, P2}, {P2, P1}, 4'd4, 3'd0, "R2");
    check("R2", "lane_cond", 64'(lane_cond), 64'b10);
  endtask

  task automatic t_zeros;  // R5
    run_vec({NZ, PZ}, {PZ, NZ}, 4'd2, 3'd1, "R5");
    check("R5", "eq zeros", 64'(lane_cond), 64'b11);
    run_vec({NZ, PZ}, {PZ, NZ}, 4'd4, 3'd1, "R5");
    check("R5", "lt zeros", 64'(lane_cond), 64'b00);
  endtask

  task automatic t_neg;  // R6
    run_vec({N1, N2}, {N2, N1}, 4'd4, 3'd2, "R6");
    check("R6", "neg order", 64'(lane_cond), 64'b01);
    run_vec({NINF, NZ}, {N2, TINY}, 4'd4, 3'd5, "R6");
    check("R6", "inf/zero order", 64'(lane_cond), 64'b11);
  endtask

  task automatic t_inv;  // R8, R9
    run_vec({P1, QNAN}, {P1, P1}, 4'd2, 3'd0, "R9");
    check("R9", "quiet nan silent", 64'(inv_op), 64'd0);
    run_vec({P1, QNAN}, {P1, P1}, 4'd10, 3'd0, "R8");
    check("R8", "sig quiet nan", 64'(inv_op), 64'd1);
    run_vec({SNAN, P1}, {P1, P1}, 4'd2, 3'd4, "R9");
    check("R9", "upper snan", 64'(inv_op), 64'd1);
  endtask

  task automatic t_bad_cc;  // R10
    logic [1:0] lc;
    lc = lane_cond;
    @(negedge clk);
    src_s = {SNAN, SNAN}; src_t = {P1, P1}; pred = 4'd15; cc_sel = 3'd7; cmp_en = 1'b1;
    @(negedge clk);
    check("R10", "cc_err", 64'(cc_err), 64'd1);
    check("R10", "inv_op", 64'(inv_op), 64'd0);
    check("R10", "ccr", 64'(ccr), 64'(exp_ccr));
    check("R10", "lane_cond", 64'(lane_cond), 64'(lc));
    cmp_en = 1'b0;
    @(negedge clk);
    check("R10", "cc_err pulse", 64'(cc_err), 64'd0);
  endtask

  task automatic t_idle;  // R11
    logic [1:0] lc;
    lc = lane_cond;
    @(negedge clk);
    src_s = {QNAN, SNAN}; src_t = {P1, N1}; pred = 4'd9; cc_sel = 3'd0; cmp_en = 1'b0;
    @(negedge clk);
    check("R11", "ccr", 64'(ccr), 64'(exp_ccr));
    check("R11", "lane_cond", 64'(lane_cond), 64'(lc));
    check("R11", "inv_op", 64'(inv_op), 64'd0);
    check("R11", "cc_err", 64'(cc_err), 64'd0);
  endtask

  task automatic t_sweep;  // R3, R4, R7
    int c = 0;
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 12; i++) begin
        for (int j = 0; j < 12; j++) begin
          logic [31:0] a0, b0, a1, b1;
          logic nan0;
          string tag;
          a0 = val(i); b0 = val(j); a1 = val(i + 3); b1 = val(j + 5);
          nan0 = (a0[30:23] == 8'hFF && a0[22:0] != 0) || (b0[30:23] == 8'hFF && b0[22:0] != 0);
          tag = (p >= 8) ? "R7" : (nan0 ? "R3" : "R4");
          run_vec({a1, a0}, {b1, b0}, 4'(p), 3'(c), tag);
          c = (c + 1) % 7;
        end
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmp_en = 1'b0; pred = '0; cc_sel = '0; src_s = '0; src_t = '0;
    exp_ccr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_zeros();
    t_neg();
    t_inv();
    t_bad_cc();
    t_idle();
    t_sweep();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule